// File: doc/BRIEF.md
# Line and Payload AIS Insertion Controller

This block decides, on every bit clock, whether the transmit line stream and the downstream payload stream carry their normal data or an alarm indication signal (AIS), and which AIS pattern is used. Software picks a two-bit line mode and a three-bit payload mode. A frame-mode select chooses between DS3 and E3 behaviour. Five live status flags report diagnostic loopback, line loopback, payload loopback, loss of signal and out-of-frame. The block acts on these flags without software involvement.

For each direction the block produces the substituted serial bit, an insert flag and a two-bit code that software can read back. There are two AIS patterns. The first is unframed all ones. The second is the DS3 AIS payload: the payload bits alternate 1,0,1,0, and any bit that the framer marks as overhead passes through unchanged. Mode fields and status flags are captured in registers. The data path is one register deep, so every output bit is either fully replaced or fully passed through.

Top module: `ais_insert_ctrl`

## Requirements
- R1: While reset is asserted, and directly after it, both insert flags are 0, both codes are 00 and both data outputs are 0.
- R2: When a direction is not inserting, its data output equals its data input from one clock edge earlier.
- R3: With line mode 00, the line direction inserts exactly while diagnostic loopback is set. The code is 10 (DS3 AIS) when frame_e3 is 0 and 01 (all ones) when frame_e3 is 1.
- R4: With line mode 01, the line direction always inserts with code 01, whatever the frame mode.
- R5: With line mode 10, the line direction always inserts. The code is 10 when frame_e3 is 0 and 01 when frame_e3 is 1.
- R6: With line mode 11, the line direction never inserts, and its code is 00.
- R7: While a direction's code is 01, every data output bit of that direction is 1.
- R8: While the line code is 10, a bit whose line_oh was 1 passes through with one cycle of latency. The other bits alternate 1,0 and start with 1 at the beginning of each insertion period. The alternation skips over overhead bits and does not restart at them.
- R9: Payload modes work as follows. 000 always inserts. 111 never inserts. 001 inserts on line loopback. 010 inserts on payload loopback. 011 inserts on either loopback.
- R10: Payload mode 100 inserts on loss of signal. Mode 101 inserts on out-of-frame. Mode 110 inserts on any of out-of-frame, loss of signal, line loopback or payload loopback.
- R11: In the payload conditions, line loopback and loss of signal count only while diagnostic loopback is clear. Payload loopback and out-of-frame are never masked.
- R12: The payload code is 01 whenever the payload direction inserts, and 00 otherwise.
- R13: A mode or status value present at clock edge k decides the outputs that are registered at edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| line_mode | input | 2 | Line AIS mode field |
| pay_mode | input | 3 | Payload AIS mode field |
| frame_e3 | input | 1 | 1 selects E3 behaviour, 0 selects DS3 |
| dlb | input | 1 | Diagnostic loopback active |
| llb | input | 1 | Line loopback active |
| plb | input | 1 | Payload loopback active |
| los | input | 1 | Loss of signal |
| oof | input | 1 | Out-of-frame |
| line_din | input | 1 | Transmit line data in |
| line_oh | input | 1 | Marks the current line bit as DS3 overhead |
| pay_din | input | 1 | Downstream payload data in |
| line_dout | output | 1 | Transmit line data out |
| line_ins | output | 1 | Line AIS being inserted |
| line_code | output | 2 | Line AIS code: 00 none, 01 all ones, 10 DS3 AIS |
| pay_dout | output | 1 | Payload data out |
| pay_ins | output | 1 | Payload AIS being inserted |
| pay_code | output | 2 | Payload AIS code: 00 none, 01 all ones |

## Verification
The hardest case to reach is the DS3 AIS pattern restarting at the right phase. To reach it, DS3 insertion is stopped part-way through the alternation, and overhead markers land both inside and at the edges of an insertion period. The stimulus toggles diagnostic loopback under line mode 00 with DS3 framing, with on and off periods of different lengths, while overhead markers arrive at a period unrelated to them. A bench-side model then checks that each period starts with 1 and skips the overhead bits. The masking rule is covered by sweeping all 32 flag combinations under each payload mode.

// File: rtl/ais_pkg.sv
package ais_pkg;

    localparam int LMODE_W = 2;
    localparam int PMODE_W = 3;
    localparam int CODE_W  = 2;

    typedef enum logic [LMODE_W-1:0] {
        LM_AUTO_DLB   = 2'b00,
        LM_FORCE_ONES = 2'b01,
        LM_FORCE_AIS  = 2'b10,
        LM_OFF        = 2'b11
    } line_mode_e;

    typedef enum logic [PMODE_W-1:0] {
        PM_ALWAYS = 3'b000,
        PM_LLB    = 3'b001,
        PM_PLB    = 3'b010,
        PM_ANY_LB = 3'b011,
        PM_LOS    = 3'b100,
        PM_OOF    = 3'b101,
        PM_ANY    = 3'b110,
        PM_NEVER  = 3'b111
    } pay_mode_e;

    typedef enum logic [CODE_W-1:0] {
        AC_NONE = 2'b00,
        AC_ONES = 2'b01,
        AC_DS3  = 2'b10
    } ais_code_e;

    typedef struct packed {
        logic dlb;
        logic llb;
        logic plb;
        logic los;
        logic oof;
    } alarm_t;

    typedef struct packed {
        logic      active;
        ais_code_e code;
    } ais_sel_t;

    // Code used by modes that follow the frame type
    function automatic ais_code_e framed_code(input logic e3);
        return e3 ? AC_ONES : AC_DS3;
    endfunction

    localparam ais_sel_t SEL_IDLE = '{active: 1'b0, code: AC_NONE};

endpackage

// File: rtl/ais_line_sel.sv
module ais_line_sel
    import ais_pkg::*;
(
    input  line_mode_e mode,
    input  logic       e3,
    input  logic       dlb,
    output ais_sel_t   sel
);
    always_comb begin
        sel = SEL_IDLE;
        unique case (mode)
            LM_AUTO_DLB: begin
                sel.active = dlb;
                sel.code   = dlb ? framed_code(e3) : AC_NONE;
            end
            LM_FORCE_ONES: begin
                sel.active = 1'b1;
                sel.code   = AC_ONES;
            end
            LM_FORCE_AIS: begin
                sel.active = 1'b1;
                sel.code   = framed_code(e3);
            end
            default: sel = SEL_IDLE;
        endcase
    end
endmodule

// File: rtl/ais_pay_sel.sv
module ais_pay_sel
    import ais_pkg::*;
(
    input  pay_mode_e mode,
    input  alarm_t    al,
    output ais_sel_t  sel
);
    logic llb_eff, los_eff, hit;

    // loopback in diagnostic mode hides line-side conditions
    assign llb_eff = al.llb & ~al.dlb;
    assign los_eff = al.los & ~al.dlb;

    always_comb begin
        unique case (mode)
            PM_ALWAYS: hit = 1'b1;
            PM_LLB:    hit = llb_eff;
            PM_PLB:    hit = al.plb;
            PM_ANY_LB: hit = llb_eff | al.plb;
            PM_LOS:    hit = los_eff;
            PM_OOF:    hit = al.oof;
            PM_ANY:    hit = al.oof | los_eff | llb_eff | al.plb;
            default:   hit = 1'b0;
        endcase
        sel.active = hit;
        sel.code   = hit ? AC_ONES : AC_NONE;
    end
endmodule

// File: rtl/ais_stream_sub.sv
module ais_stream_sub
    import ais_pkg::*;
#(
    parameter bit DS3_CAPABLE = 1'b1
) (
    input  logic      clk,
    input  logic      rst,
    input  ais_sel_t  sel,
    input  logic      din,
    input  logic      oh,
    output logic      dout,
    output logic      ins,
    output ais_code_e code
);
    logic phase;
    logic fill_bit;

    generate
        if (DS3_CAPABLE) begin : g_ds3
            logic run_ds3;
            assign run_ds3 = sel.active && (sel.code == AC_DS3);
            always_ff @(posedge clk) begin
                if (rst)          phase <= 1'b1;
                else if (run_ds3) phase <= oh ? phase : ~phase;
                else              phase <= 1'b1;
            end
        end else begin : g_ones
            assign phase = 1'b1;
        end
    endgenerate

    assign fill_bit = (sel.code == AC_DS3) ? (oh ? din : phase) : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= 1'b0;
            ins  <= 1'b0;
            code <= AC_NONE;
        end else begin
            dout <= sel.active ? fill_bit : din;
            ins  <= sel.active;
            code <= sel.active ? sel.code : AC_NONE;
        end
    end
endmodule

// File: rtl/ais_insert_ctrl.sv
module ais_insert_ctrl
    import ais_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] line_mode,
    input  logic [2:0] pay_mode,
    input  logic       frame_e3,
    input  logic       dlb,
    input  logic       llb,
    input  logic       plb,
    input  logic       los,
    input  logic       oof,
    input  logic       line_din,
    input  logic       line_oh,
    input  logic       pay_din,
    output logic       line_dout,
    output logic       line_ins,
    output logic [1:0] line_code,
    output logic       pay_dout,
    output logic       pay_ins,
    output logic [1:0] pay_code
);
    line_mode_e lmode_q;
    pay_mode_e  pmode_q;
    logic       e3_q;
    alarm_t     al_q;
    ais_sel_t   line_sel, pay_sel;
    ais_code_e  line_code_e, pay_code_e;

    always_ff @(posedge clk) begin
        if (rst) begin
            lmode_q <= LM_OFF;
            pmode_q <= PM_NEVER;
            e3_q    <= 1'b0;
            al_q    <= '0;
        end else begin
            lmode_q <= line_mode_e'(line_mode);
            pmode_q <= pay_mode_e'(pay_mode);
            e3_q    <= frame_e3;
            al_q    <= '{dlb: dlb, llb: llb, plb: plb, los: los, oof: oof};
        end
    end

    ais_line_sel u_line_sel (
        .mode (lmode_q),
        .e3   (e3_q),
        .dlb  (al_q.dlb),
        .sel  (line_sel)
    );

    ais_pay_sel u_pay_sel (
        .mode (pmode_q),
        .al   (al_q),
        .sel  (pay_sel)
    );

    ais_stream_sub #(.DS3_CAPABLE(1'b1)) u_line_sub (
        .clk  (clk),
        .rst  (rst),
        .sel  (line_sel),
        .din  (line_din),
        .oh   (line_oh),
        .dout (line_dout),
        .ins  (line_ins),
        .code (line_code_e)
    );

    ais_stream_sub #(.DS3_CAPABLE(1'b0)) u_pay_sub (
        .clk  (clk),
        .rst  (rst),
        .sel  (pay_sel),
        .din  (pay_din),
        .oh   (1'b0),
        .dout (pay_dout),
        .ins  (pay_ins),
        .code (pay_code_e)
    );

    assign line_code = line_code_e;
    assign pay_code  = pay_code_e;
endmodule

// File: rtl/ais_insert_chk.sv
module ais_insert_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] line_mode,
    input logic [2:0] pay_mode,
    input logic       line_din,
    input logic       line_oh,
    input logic       pay_din,
    input logic       line_dout,
    input logic       line_ins,
    input logic [1:0] line_code,
    input logic       pay_dout,
    input logic       pay_ins,
    input logic [1:0] pay_code
);
    // R2
    line_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (!line_ins && !$past(rst)) |-> line_dout == $past(line_din));

    // R2
    pay_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (!pay_ins && !$past(rst)) |-> pay_dout == $past(pay_din));

    // R4
    line_force_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (line_mode == 2'b01) |-> ##2 (line_ins && line_code == 2'b01));

    // R6
    line_off_chk: assert property (@(posedge clk) disable iff (rst)
        (line_mode == 2'b11) |-> ##2 (!line_ins && line_code == 2'b00));

    // R7
    line_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (line_code == 2'b01) |-> line_dout);

    // R8
    ds3_oh_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (line_code == 2'b10 && $past(line_oh)) |-> line_dout == $past(line_din));

    // R9
    pay_never_chk: assert property (@(posedge clk) disable iff (rst)
        (pay_mode == 3'b111) |-> ##2 !pay_ins);

    // R12
    pay_code_chk: assert property (@(posedge clk) disable iff (rst)
        pay_ins ? (pay_code == 2'b01 && pay_dout) : (pay_code == 2'b00));
endmodule

bind ais_insert_ctrl ais_insert_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .line_mode (line_mode),
    .pay_mode  (pay_mode),
    .line_din  (line_din),
    .line_oh   (line_oh),
    .pay_din   (pay_din),
    .line_dout (line_dout),
    .line_ins  (line_ins),
    .line_code (line_code),
    .pay_dout  (pay_dout),
    .pay_ins   (pay_ins),
    .pay_code  (pay_code)
);

// File: tb/sim_ais_insert_ctrl.sv
module sim_ais_insert_ctrl;

    typedef struct packed {
        logic       li;
        logic [1:0] lc;
        logic       ld;
        logic       pi;
        logic [1:0] pc;
        logic       pd;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] line_mode = 2'b11;
    logic [2:0] pay_mode = 3'b111;
    logic       frame_e3 = 1'b0;
    logic       dlb = 1'b0, llb = 1'b0, plb = 1'b0, los = 1'b0, oof = 1'b0;
    logic       line_din = 1'b0, line_oh = 1'b0, pay_din = 1'b0;
    logic       line_dout, line_ins, pay_dout, pay_ins;
    logic [1:0] line_code, pay_code;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    exp_t  exp_q[$];
    string tag_q[$];

    // model state: values presented at the previous edge
    logic [1:0] p_lm = 2'b11;
    logic [2:0] p_pm = 3'b111;
    logic       p_e3 = 1'b0;
    logic [4:0] p_fl = 5'b0;
    logic       m_phase = 1'b1;

    always #2.5 clk = ~clk;

    ais_insert_ctrl u0 (
        .clk(clk), .rst(rst), .line_mode(line_mode), .pay_mode(pay_mode),
        .frame_e3(frame_e3), .dlb(dlb), .llb(llb), .plb(plb), .los(los), .oof(oof),
        .line_din(line_din), .line_oh(line_oh), .pay_din(pay_din),
        .line_dout(line_dout), .line_ins(line_ins), .line_code(line_code),
        .pay_dout(pay_dout), .pay_ins(pay_ins), .pay_code(pay_code)
    );

    // fl = {dlb, llb, plb, los, oof}
    task automatic step(input logic [1:0] lm, input logic [2:0] pm, input logic e3,
                        input logic [4:0] fl, input logic ld, input logic lo,
                        input logic pd, input string tag);
        exp_t e;
        logic d, le, pe;
        @(negedge clk);
        line_mode = lm; pay_mode = pm; frame_e3 = e3;
        {dlb, llb, plb, los, oof} = fl;
        line_din = ld; line_oh = lo; pay_din = pd;
        d  = p_fl[4];
        le = p_fl[3] & ~d;
        pe = p_fl[1] & ~d;
        // line decision (R3..R6) from previous-edge values (R13)
        case (p_lm)
            2'b00: begin e.li = d;    e.lc = p_e3 ? 2'b01 : 2'b10; end
            2'b01: begin e.li = 1'b1; e.lc = 2'b01; end
            2'b10: begin e.li = 1'b1; e.lc = p_e3 ? 2'b01 : 2'b10; end
            default: begin e.li = 1'b0; e.lc = 2'b00; end
        endcase
        if (!e.li) e.lc = 2'b00;
        if (!e.li)              e.ld = ld;
        else if (e.lc == 2'b01) e.ld = 1'b1;
        else                    e.ld = lo ? ld : m_phase;
        if (e.li && e.lc == 2'b10) begin
            if (!lo) m_phase = ~m_phase;
        end else begin
            m_phase = 1'b1;
        end
        // payload decision (R9..R12)
        case (p_pm)
            3'd0: e.pi = 1'b1;
            3'd1: e.pi = le;
            3'd2: e.pi = p_fl[2];
            3'd3: e.pi = le | p_fl[2];
            3'd4: e.pi = pe;
            3'd5: e.pi = p_fl[0];
            3'd6: e.pi = p_fl[0] | pe | le | p_fl[2];
            default: e.pi = 1'b0;
        endcase
        e.pc = e.pi ? 2'b01 : 2'b00;
        e.pd = e.pi ? 1'b1 : pd;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        p_lm = lm; p_pm = pm; p_e3 = e3; p_fl = fl;
    endtask

    // scoreboard monitor
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t  e;
            exp_t  a;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = '{li: line_ins, lc: line_code, ld: line_dout,
                  pi: pay_ins, pc: pay_code, pd: pay_dout};
            n_cmp++;
            if (a !== e) begin
                n_bad++;
                $display("FAIL %s: actual li=%b lc=%b ld=%b pi=%b pc=%b pd=%b expected li=%b lc=%b ld=%b pi=%b pc=%b pd=%b",
                         t, a.li, a.lc, a.ld, a.pi, a.pc, a.pd,
                         e.li, e.lc, e.ld, e.pi, e.pc, e.pd);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        // R1: reset state, with inputs busy
        line_mode = 2'b01; pay_mode = 3'b000; line_din = 1'b1; pay_din = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            n_cmp++;
            if ({line_ins, line_code, line_dout, pay_ins, pay_code, pay_dout} !== 8'b0) begin
                n_bad++;
                $display("FAIL R1: actual %b expected 00000000",
                         {line_ins, line_code, line_dout, pay_ins, pay_code, pay_dout});
            end
        end
        line_mode = 2'b11; pay_mode = 3'b111; line_din = 1'b0; pay_din = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        n_cmp++;
        if ({line_ins, line_code, line_dout, pay_ins, pay_code, pay_dout} !== 8'b0) begin
            n_bad++;
            $display("FAIL R1: actual %b expected 00000000 after release",
                     {line_ins, line_code, line_dout, pay_ins, pay_code, pay_dout});
        end

        // R2 / R6: pass-through with everything disabled
        for (int i = 0; i < 24; i++)
            step(2'b11, 3'b111, i[0], 5'b11111, 1'($urandom_range(0, 1)), 1'(i % 3 == 0),
                 1'($urandom_range(0, 1)), "R2_R6 passthrough");

        // R4 / R7: forced all ones, both frame modes
        for (int i = 0; i < 16; i++)
            step(2'b01, 3'b111, 1'(i >= 8), 5'b0, 1'($urandom_range(0, 1)), 1'(i % 4 == 1),
                 1'($urandom_range(0, 1)), "R4_R7 force ones");

        // R5 / R8: forced AIS, DS3 with overhead markers, then E3
        for (int i = 0; i < 30; i++)
            step(2'b10, 3'b111, 1'b0, 5'b0, 1'($urandom_range(0, 1)), 1'(i % 7 == 6),
                 1'b0, "R5_R8 ds3 ais");
        for (int i = 0; i < 10; i++)
            step(2'b10, 3'b111, 1'b1, 5'b0, 1'($urandom_range(0, 1)), 1'(i % 3 == 0),
                 1'b0, "R5 e3 ais");

        // R13: mode change mid-stream; old mode governs one more bit
        step(2'b11, 3'b000, 1'b0, 5'b0, 1'b0, 1'b0, 1'b0, "R13 switch off");
        step(2'b11, 3'b000, 1'b0, 5'b0, 1'b0, 1'b0, 1'b0, "R13 switched");

        // R3 / R8: diagnostic loopback toggling, restart of alternation
        for (int i = 0; i < 60; i++)
            step(2'b00, 3'b111, 1'(i >= 45), {1'((i % 11) < 6), 4'b0},
                 1'($urandom_range(0, 1)), 1'(i % 5 == 2), 1'b0, "R3_R8 auto dlb");

        // R9 / R10 / R11 / R12: payload mode sweep over all flag patterns
        for (int m = 0; m < 8; m++)
            for (int f = 0; f < 32; f++)
                step(2'b00, 3'(m), 1'(f % 2), 5'(f), 1'($urandom_range(0, 1)),
                     1'(f % 5 == 4), 1'($urandom_range(0, 1)),
                     (m == 0 || m == 7 || m < 4) ? "R9_R11_R12 payload" : "R10_R11_R12 payload");

        step(2'b11, 3'b111, 1'b0, 5'b0, 1'b0, 1'b0, 1'b0, "R2 tail");
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule